// File: doc/BRIEF.md
# Minimal Accumulator Computer

This block is a complete small stored-program computer built around one 8-bit accumulator. Code and data share a 16-word by 8-bit RAM. Each instruction word holds an operation code in its upper nibble and an operand address in its lower nibble. All datapath transfers pass over a single internal 8-bit bus. In any cycle at most one of four sources drives that bus: the RAM read port, the ALU result, the memory address register or the program counter. The other datapath registers are an 8-bit operand register, a 4-bit instruction register, a 4-bit memory address register and a 4-bit program counter. The program counter is an up-counter that can also be loaded in parallel.

A four-step timing sequencer controls every instruction, with a fifth stop state. `FETCH_A` copies the program counter to the address register. `FETCH_B` reads the instruction word, splits it into the opcode and the address, and advances the program counter. `EXEC_A` and `EXEC_B` carry out the instruction. The transitions are:
- `FETCH_A` goes to `FETCH_B`.
- `FETCH_B` goes back to `FETCH_A` for a no-operation opcode, and to `EXEC_A` for any other opcode.
- `EXEC_A` goes to `EXEC_B` for load, add and and; to `STOPPED` for halt; and to `FETCH_A` otherwise.
- `EXEC_B` goes to `FETCH_A`.
- `STOPPED` stays in `STOPPED`.

The program image is a parameter, and the RAM is set to it while reset is held. After the program halts, a side read port lets the surrounding logic inspect the RAM.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, `halted` is 0, the program counter and accumulator are 0, and every RAM word equals its byte in `INIT_IMAGE`. Word i is held in bits [8i+7:8i]. After reset is released, execution starts at address 0.
- R2: An instruction word decodes as opcode = bits [7:4] and operand address = bits [3:0]. The opcodes are 0 no-op, 1 halt, 2 load, 3 store, 4 jump, 5 branch-if-zero, 6 and, 7 add. Opcodes 8 to 15 behave as no-op.
- R3: Counted in clock edges, a no-op takes 2 cycles. Store, jump, branch and halt take 3 cycles. Load, and, and add take 4 cycles. The `halted` output rises on the last edge of the halt instruction.
- R4: A load instruction copies RAM[address] into the accumulator.
- R5: An add instruction sets the accumulator to (accumulator + RAM[address]) mod 256. No carry or overflow flag is kept.
- R6: An and instruction sets the accumulator to the bitwise AND of the accumulator and RAM[address].
- R7: A store instruction writes the accumulator to RAM[address]. No other instruction changes the RAM.
- R8: A jump instruction sets the program counter to its operand address.
- R9: A branch-if-zero instruction sets the program counter to its operand address only when the accumulator is 0. Otherwise execution continues in sequence.
- R10: Once a halt instruction has executed, `halted` stays 1 and no further instruction runs, until reset.
- R11: The program counter wraps from 15 to 0 when it advances past the last address.
- R12: In every cycle at most one bus source is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads the RAM image |
| halted | output | 1 | High once a halt instruction has completed |
| dbg_addr | input | 4 | RAM word selected for inspection |
| dbg_data | output | 8 | Combinational read of RAM[dbg_addr] |

## Verification
Results arrive in two forms:
- **`halted`.** Each program's `halted` rise falls on an edge count that follows from R3. Counting from the reset release, it is due on edge 106 for the three-pass summing loop, edge 28 for the wrap-around program and edge 3 for the single-halt program. The bench samples `halted` at the falling edge after edges H-1 and H, where it must be 0 and then 1. It samples it again long after halt.
- **RAM words.** Memory results settle into RAM by the halt edge. They are queued as expected items and compared through the side read port only after `halted` has risen, one item per nanosecond-settled read. The same port confirms the image during reset.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP = 4'd0,
        OP_HLT = 4'd1,
        OP_LDA = 4'd2,
        OP_STA = 4'd3,
        OP_JMP = 4'd4,
        OP_BEZ = 4'd5,
        OP_AND = 4'd6,
        OP_ADD = 4'd7
    } opcode_e;

    typedef enum logic [2:0] {
        FETCH_A = 3'd0,
        FETCH_B = 3'd1,
        EXEC_A  = 3'd2,
        EXEC_B  = 3'd3,
        STOPPED = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic mem_drv;
        logic alu_drv;
        logic ma_drv;
        logic pc_drv;
        logic ld_acc;
        logic ld_opnd;
        logic ld_ir;
        logic ld_ma;
        logic pc_load;
        logic pc_step;
        logic mem_wr;
        logic alu_logic;
        logic alu_fsel;
        logic alu_cin;
    } ctl_t;

    function automatic logic is_noop(input logic [OPC_W-1:0] op);
        return (op == OP_NOP) || op[OPC_W-1];
    endfunction

    function automatic logic needs_second_exec(input logic [OPC_W-1:0] op);
        return (op == OP_LDA) || (op == OP_AND) || (op == OP_ADD);
    endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         logic_mode,
    input  logic         fsel,
    input  logic         cin,
    output logic [W-1:0] y,
    output logic         a_zero
);

    logic [W-1:0] addend;

    always_comb begin
        addend = fsel ? b : '0;
        if (logic_mode) begin
            y = fsel ? b : (a & b);
        end else begin
            y = a + addend + {{(W-1){1'b0}}, cin};
        end
        a_zero = (a == '0);
    end

endmodule

// File: rtl/acc_cpu_pc.sv
module acc_cpu_pc #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end else if (step) begin
            q <= q + 1'b1;
        end
    end

    // R11: advancing wraps modulo the address space
    p_pc_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (q == AW'($past(q) + 1'b1)));

    // R8: a parallel load takes the bus address
    p_pc_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(din)));

endmodule

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
    parameter int AW = 4,
    parameter int DW = 8,
    parameter logic [((1<<AW)*DW)-1:0] IMAGE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] dbg_addr,
    output logic [DW-1:0] dbg_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= IMAGE[i*DW +: DW];
            end
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata    = mem[addr];
    assign dbg_data = mem[dbg_addr];

    // R7: a write lands at the addressed word
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  opcode_e    bus_opc,
    input  opcode_e    ir,
    input  logic       a_zero,
    output seq_state_e state,
    output ctl_t       ctl
);

    seq_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FETCH_A;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            FETCH_A: nxt = FETCH_B;
            FETCH_B: nxt = is_noop(bus_opc) ? FETCH_A : EXEC_A;
            EXEC_A: begin
                if (needs_second_exec(ir))  nxt = EXEC_B;
                else if (ir == OP_HLT)      nxt = STOPPED;
                else                        nxt = FETCH_A;
            end
            EXEC_B:  nxt = FETCH_A;
            STOPPED: nxt = STOPPED;
            default: nxt = FETCH_A;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state)
            FETCH_A: begin
                ctl.pc_drv = 1'b1;
                ctl.ld_ma  = 1'b1;
            end
            FETCH_B: begin
                ctl.mem_drv = 1'b1;
                ctl.ld_ir   = 1'b1;
                ctl.ld_ma   = 1'b1;
                ctl.pc_step = 1'b1;
            end
            EXEC_A: begin
                unique case (ir)
                    OP_LDA, OP_AND, OP_ADD: begin
                        ctl.mem_drv = 1'b1;
                        ctl.ld_opnd = 1'b1;
                    end
                    OP_STA: begin
                        ctl.alu_drv   = 1'b1;
                        ctl.alu_logic = 1'b0;
                        ctl.alu_fsel  = 1'b0;
                        ctl.mem_wr    = 1'b1;
                    end
                    OP_JMP: begin
                        ctl.ma_drv  = 1'b1;
                        ctl.pc_load = 1'b1;
                    end
                    OP_BEZ: begin
                        ctl.ma_drv  = a_zero;
                        ctl.pc_load = a_zero;
                    end
                    default: ;
                endcase
            end
            EXEC_B: begin
                ctl.alu_drv = 1'b1;
                ctl.ld_acc  = 1'b1;
                unique case (ir)
                    OP_LDA: begin
                        ctl.alu_logic = 1'b1;
                        ctl.alu_fsel  = 1'b1;
                    end
                    OP_AND: begin
                        ctl.alu_logic = 1'b1;
                        ctl.alu_fsel  = 1'b0;
                    end
                    default: begin
                        ctl.alu_logic = 1'b0;
                        ctl.alu_fsel  = 1'b1;
                    end
                endcase
            end
            STOPPED: ;
            default: ;
        endcase
    end

    // R10: the stop state is never left without reset
    p_stop_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == STOPPED) |=> (state == STOPPED));

    // R3: the fetch pair always runs in order
    p_fetch_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FETCH_A) |=> (state == FETCH_B));

    // R2: no-op class opcodes return straight to fetch
    p_noop_skips_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FETCH_B && is_noop(bus_opc)) |=> (state == FETCH_A));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [((1<<ADDR_W)*(acc_cpu_pkg::OPC_W+ADDR_W))-1:0] INIT_IMAGE = '0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    output logic                           halted,
    input  logic [ADDR_W-1:0]              dbg_addr,
    output logic [acc_cpu_pkg::OPC_W+ADDR_W-1:0] dbg_data
);

    localparam int DW = OPC_W + ADDR_W;

    seq_state_e    state;
    ctl_t          ctl;
    opcode_e       ir;
    logic [DW-1:0] acc;
    logic [DW-1:0] opnd;
    logic [ADDR_W-1:0] ma;
    logic [ADDR_W-1:0] pc;
    logic [DW-1:0] bus;
    logic [DW-1:0] mem_q;
    logic [DW-1:0] alu_y;
    logic          a_zero;

    acc_cpu_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_opc (opcode_e'(bus[DW-1:ADDR_W])),
        .ir      (ir),
        .a_zero  (a_zero),
        .state   (state),
        .ctl     (ctl)
    );

    acc_cpu_alu #(.W(DW)) u_alu (
        .a          (acc),
        .b          (opnd),
        .logic_mode (ctl.alu_logic),
        .fsel       (ctl.alu_fsel),
        .cin        (ctl.alu_cin),
        .y          (alu_y),
        .a_zero     (a_zero)
    );

    acc_cpu_pc #(.AW(ADDR_W)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctl.pc_load),
        .step  (ctl.pc_step),
        .din   (bus[ADDR_W-1:0]),
        .q     (pc)
    );

    acc_cpu_ram #(.AW(ADDR_W), .DW(DW), .IMAGE(INIT_IMAGE)) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctl.mem_wr),
        .addr     (ma),
        .wdata    (bus),
        .rdata    (mem_q),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data)
    );

    // AND-OR bus: each source gated by its own enable
    always_comb begin
        bus = ({DW{ctl.mem_drv}} & mem_q)
            | ({DW{ctl.alu_drv}} & alu_y)
            | ({DW{ctl.ma_drv}}  & {{OPC_W{1'b0}}, ma})
            | ({DW{ctl.pc_drv}}  & {{OPC_W{1'b0}}, pc});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            opnd <= '0;
            ir   <= OP_NOP;
            ma   <= '0;
        end else begin
            if (ctl.ld_acc)  acc  <= bus;
            if (ctl.ld_opnd) opnd <= bus;
            if (ctl.ld_ir)   ir   <= opcode_e'(bus[DW-1:ADDR_W]);
            if (ctl.ld_ma)   ma   <= bus[ADDR_W-1:0];
        end
    end

    assign halted = (state == STOPPED);

    // R12: at most one bus source per cycle
    p_one_driver_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl.mem_drv, ctl.alu_drv, ctl.ma_drv, ctl.pc_drv}));

    // R7: RAM written only by a store in its execute step
    p_write_only_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mem_wr |-> (state == EXEC_A && ir == OP_STA));

    // R5: add wraps modulo the word width
    p_add_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EXEC_B && ir == OP_ADD) |=> (acc == DW'($past(acc) + $past(opnd))));

    // R9: a branch on a nonzero accumulator leaves the PC alone
    p_bez_not_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EXEC_A && ir == OP_BEZ && acc != '0) |=> $stable(pc));

    // R4: a load copies the operand register into the accumulator
    p_load_copies_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EXEC_B && ir == OP_LDA) |=> (acc == $past(opnd)));

endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;

    localparam int RUN_EDGES = 130;
    localparam int H_LOOP = 106;
    localparam int H_WRAP = 28;
    localparam int H_STOP = 3;

    // word i at bits [8i+7:8i]
    localparam logic [127:0] IMG_LOOP = 128'h0000FF030F0010403C7D2C3A7B2A592C;
    localparam logic [127:0] IMG_WRAP = 128'h699F007A2AC83F00000000000010385B;
    localparam logic [127:0] IMG_STOP = 128'h55000000000000000000000000003F10;

    typedef struct {
        int         unit;
        logic [3:0] addr;
        logic [7:0] data;
        string      tag;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] dbg_addr = '0;
    logic       halted_loop, halted_wrap, halted_stop;
    logic [7:0] data_loop, data_wrap, data_stop;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit mon_busy = 1'b0;
    sb_item_t sb_q[$];

    always #10 clk = ~clk;

    acc_cpu #(.ADDR_W(4), .INIT_IMAGE(IMG_LOOP)) u_acc_cpu (
        .clk(clk), .rst_n(rst_n), .halted(halted_loop),
        .dbg_addr(dbg_addr), .dbg_data(data_loop));

    acc_cpu #(.ADDR_W(4), .INIT_IMAGE(IMG_WRAP)) u_acc_cpu_wrap (
        .clk(clk), .rst_n(rst_n), .halted(halted_wrap),
        .dbg_addr(dbg_addr), .dbg_data(data_wrap));

    acc_cpu #(.ADDR_W(4), .INIT_IMAGE(IMG_STOP)) u_acc_cpu_stop (
        .clk(clk), .rst_n(rst_n), .halted(halted_stop),
        .dbg_addr(dbg_addr), .dbg_data(data_stop));

    task automatic check(input logic ok, input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic expect_word(input int unit, input logic [3:0] addr,
                               input logic [7:0] data, input string tag);
        sb_item_t it;
        it.unit = unit;
        it.addr = addr;
        it.data = data;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        wait (sb_q.size() == 0 && !mon_busy);
        #1;
    endtask

    // monitor: pops expected words and compares through the side port
    initial begin
        forever begin
            sb_item_t it;
            logic [7:0] got;
            wait (sb_q.size() != 0);
            mon_busy = 1'b1;
            it = sb_q.pop_front();
            dbg_addr = it.addr;
            #1;
            got = (it.unit == 0) ? data_loop : (it.unit == 1) ? data_wrap : data_stop;
            check(got == it.data, it.tag, got, it.data);
            mon_busy = 1'b0;
            #1;
        end
    end

    task automatic check_halt(input int edge_n, input int h, input logic val, input string tag);
        if (edge_n == h - 1 || edge_n == h || edge_n == RUN_EDGES) begin
            check(val == (edge_n >= h), tag, {7'd0, val}, {7'd0, (edge_n >= h)});
        end
    endtask

    initial begin
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(!halted_loop && !halted_wrap && !halted_stop, "R1 halted low in reset",
              {5'd0, halted_loop, halted_wrap, halted_stop}, 8'h00);
        expect_word(0, 4'h0, 8'h2C, "R1 image word 0 loop");
        expect_word(1, 4'hA, 8'hC8, "R1 image word A wrap");
        expect_word(2, 4'hF, 8'h55, "R1 image word F stop");
        drain();
        @(negedge clk);
        rst_n = 1'b1;

        for (int n = 1; n <= RUN_EDGES; n++) begin
            @(posedge clk);
            @(negedge clk);
            // R3 cycle counts; R9 taken and not-taken branches set the loop length
            check_halt(n, H_LOOP, halted_loop, "R3 R9 loop halt edge");
            // R2 no-op class, R11 wrap, R9 both branch ways
            check_halt(n, H_WRAP, halted_wrap, "R2 R11 wrap halt edge");
            // R10 immediate halt
            check_halt(n, H_STOP, halted_stop, "R10 stop halt edge");
        end

        // R4 R5 R7 R8: three-pass sum reaches 45, counter reaches 0
        expect_word(0, 4'hA, 8'h2D, "R5 R7 R8 sum word");
        expect_word(0, 4'hC, 8'h00, "R4 R9 counter word");
        expect_word(0, 4'hB, 8'h0F, "R7 addend untouched");
        expect_word(0, 4'hD, 8'hFF, "R7 decrement untouched");
        expect_word(0, 4'h8, 8'h40, "R7 code untouched");
        // R5 R6 R11: (C8+C8) mod 256 = 90, AND 3F = 10, stored after wrap
        expect_word(1, 4'h8, 8'h10, "R5 R6 R11 result word");
        expect_word(1, 4'hA, 8'hC8, "R7 wrap data untouched");
        expect_word(1, 4'hF, 8'h69, "R2 R7 wrap code untouched");
        // R10: the store after the halt never runs
        expect_word(2, 4'hF, 8'h55, "R10 no execution after halt");
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule